// File: doc/BRIEF.md
# Barrel shifter with carry out

This block is the operand shifter of a small integer data path. It takes a 32-bit operand and shifts or rotates it by an 8-bit amount. Five operations are available: logical left, logical right, arithmetic right, rotate right, and a one-place rotate through the carry flag. Next to the shifted value it produces the carry flag that the operation leaves behind.

Each operation has its own rules for an amount of zero, an amount of exactly the word width, and an amount above the word width. These rules are part of the block, so the surrounding data path can pass a register-sourced amount in unchanged. The shift network is combinational. With the default setting, one output register holds the result and the carry, so the answer appears one clock after the inputs. Decoding immediates, reading the register file and writing flags back are left to the data path around the block.

Top module: `bsh_core`

## Requirements
- R1: While `rst_n` is low, `res` and `cout` are 0. With `OUT_REG`=1, `res` and `cout` show the result for the inputs that were present at the previous rising clock edge.
- R2: `kind` selects the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate right through carry. For codes 0 to 3, an amount of 0 returns the operand unchanged and returns `cin` as the carry.
- R3: Logical left by n, with n from 1 to 32, returns op<<n and carry op[32-n]. At n=32 this gives a zero result and carry op[0].
- R4: Logical left by more than 32 returns 0 with carry 0.
- R5: Logical right by n, with n from 1 to 32, returns op>>n and carry op[n-1]. Any amount above 32 returns 0 with carry 0.
- R6: Arithmetic right by n, with n from 1 to 32, fills the vacated upper bits with op[31] and returns carry op[n-1]. Any amount above 32 returns op[31] in all 32 bits and as the carry.
- R7: Rotate right by a nonzero amount rotates by the amount modulo 32, and the carry equals bit 31 of the rotated value. A nonzero multiple of 32 returns the operand with carry op[31].
- R8: Code 4 ignores the amount and returns {cin, op[31:1]} with carry op[0].
- R9: Codes 5, 6 and 7 return the operand unchanged and return `cin` as the carry, whatever the amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 32 | Operand to shift |
| kind | input | 3 | Operation code |
| amt | input | 8 | Shift or rotate amount |
| cin | input | 1 | Incoming carry flag |
| res | output | 32 | Shifted or rotated result |
| cout | output | 1 | Outgoing carry flag |

## Verification
The bench runs every operation code, including the three undefined ones, over every amount from 0 to 255 with random operands and random carry-in. This covers the edges at 0, 1, 31, 32, 33 and the multiples of 32, which separate the in-range, exact-width and over-width branches. Directed operands then check particular bits. A single set bit in the last position shifted out tells whether the carry is taken from the correct bit. A negative operand separates arithmetic fill from logical fill. A carry-in of 1 into the through-carry rotate shows that the flag enters bit 31 and not bit 0.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/bsh_amt_class.sv
module bsh_amt_class #(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int CNT_W = $clog2(W) + 1
) (
  input  logic [AMT_W-1:0] amt,
  input  logic             is_rot,
  output logic             amt_zero,
  output logic             amt_over,
  output logic [CNT_W-1:0] cnt
);
  localparam int LOG_W = $clog2(W);

  always_comb begin
    amt_zero = (amt == '0);
    amt_over = (amt > AMT_W'(W));
    if (is_rot)
      cnt = {1'b0, amt[LOG_W-1:0]};
    else if (amt_over)
      cnt = CNT_W'(W);
    else
      cnt = amt[CNT_W-1:0];
  end
endmodule

// File: rtl/bsh_right_net.sv
module bsh_right_net #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W) + 1,
  parameter int VW    = 2 * W + 1
) (
  input  logic [VW-1:0]    din,
  input  logic [CNT_W-1:0] cnt,
  output logic [VW-1:0]    dout
);
  logic [VW-1:0] stage [CNT_W+1];

  assign stage[0] = din;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    assign stage[s+1] = cnt[s] ? (stage[s] >> (2 ** s)) : stage[s];
  end

  assign dout = stage[CNT_W];
endmodule

// File: rtl/bsh_result_sel.sv
module bsh_result_sel
  import bsh_pkg::*;
#(
  parameter int W  = 32,
  parameter int VW = 2 * W + 1
) (
  input  logic [2:0]    kind,
  input  logic [W-1:0]  op,
  input  logic          cin,
  input  logic          amt_zero,
  input  logic          amt_over,
  input  logic [VW-1:0] net_out,
  output logic [W-1:0]  res_d,
  output logic          cout_d
);
  logic [W-1:0] sh_res;
  logic [W-1:0] rev_res;
  logic         sh_c;

  always_comb begin
    sh_res = net_out[W:1];
    sh_c   = net_out[0];
    for (int i = 0; i < W; i++) rev_res[i] = sh_res[W-1-i];
  end

  always_comb begin
    res_d  = op;
    cout_d = cin;
    case (kind)
      SK_LSL: begin
        if (!amt_zero) begin
          res_d  = amt_over ? '0 : rev_res;
          cout_d = amt_over ? 1'b0 : sh_c;
        end
      end
      SK_LSR: begin
        if (!amt_zero) begin
          res_d  = amt_over ? '0 : sh_res;
          cout_d = amt_over ? 1'b0 : sh_c;
        end
      end
      SK_ASR: begin
        if (!amt_zero) begin
          res_d  = amt_over ? {W{op[W-1]}} : sh_res;
          cout_d = amt_over ? op[W-1] : sh_c;
        end
      end
      SK_ROR: begin
        if (!amt_zero) begin
          res_d  = sh_res;
          cout_d = sh_res[W-1];
        end
      end
      SK_RRX: begin
        res_d  = {cin, op[W-1:1]};
        cout_d = op[0];
      end
      default: begin
        res_d  = op;
        cout_d = cin;
      end
    endcase
  end
endmodule

// File: rtl/bsh_core.sv
module bsh_core
  import bsh_pkg::*;
#(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     op,
  input  logic [2:0]       kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam int CNT_W = $clog2(W) + 1;
  localparam int VW    = 2 * W + 1;

  logic             amt_zero;
  logic             amt_over;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     rev_op;
  logic [W-1:0]     low_src;
  logic [W-1:0]     high_fill;
  logic [VW-1:0]    net_in;
  logic [VW-1:0]    net_out;
  logic [W-1:0]     res_d;
  logic             cout_d;

  bsh_amt_class #(.W(W), .AMT_W(AMT_W), .CNT_W(CNT_W)) u_amt (
    .amt      (amt),
    .is_rot   (kind == SK_ROR),
    .amt_zero (amt_zero),
    .amt_over (amt_over),
    .cnt      (cnt)
  );

  // Left shifts run through the right network on a bit-reversed operand;
  // rotates put a second copy of the operand above it; right shifts put fill there.
  always_comb begin
    for (int i = 0; i < W; i++) rev_op[i] = op[W-1-i];
    low_src   = (kind == SK_LSL) ? rev_op : op;
    high_fill = (kind == SK_ROR) ? op : {W{(kind == SK_ASR) & op[W-1]}};
    net_in    = {high_fill, low_src, 1'b0};
  end

  bsh_right_net #(.W(W), .CNT_W(CNT_W), .VW(VW)) u_net (
    .din  (net_in),
    .cnt  (cnt),
    .dout (net_out)
  );

  bsh_result_sel #(.W(W), .VW(VW)) u_sel (
    .kind     (kind),
    .op       (op),
    .cin      (cin),
    .amt_zero (amt_zero),
    .amt_over (amt_over),
    .net_out  (net_out),
    .res_d    (res_d),
    .cout_d   (cout_d)
  );

  if (OUT_REG) begin : g_reg
    logic [W-1:0] res_q;
    logic         cout_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q  <= '0;
        cout_q <= 1'b0;
      end else begin
        res_q  <= res_d;
        cout_q <= cout_d;
      end
    end

    assign res  = res_q;
    assign cout = cout_q;

    a_r2_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (amt == '0 && kind <= 3'd3) |=> (res == $past(op) && cout == $past(cin)))
      else $error("a_r2_zero_pass");

    a_r4_lsl_over: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SK_LSL && amt > AMT_W'(W)) |=> (res == '0 && !cout))
      else $error("a_r4_lsl_over");

    a_r5_lsr_over: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SK_LSR && amt > AMT_W'(W)) |=> (res == '0 && !cout))
      else $error("a_r5_lsr_over");

    a_r6_asr_over: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SK_ASR && amt > AMT_W'(W)) |=>
        (res == {W{$past(op[W-1])}} && cout == $past(op[W-1])))
      else $error("a_r6_asr_over");

    a_r7_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SK_ROR && amt != '0) |=> (cout == res[W-1]))
      else $error("a_r7_ror_carry");

    a_r8_rrx: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SK_RRX) |=>
        (res == {$past(cin), $past(op[W-1:1])} && cout == $past(op[0])))
      else $error("a_r8_rrx");

    a_r9_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (kind > 3'd4) |=> (res == $past(op) && cout == $past(cin)))
      else $error("a_r9_undef");
  end else begin : g_comb
    assign res  = res_d;
    assign cout = cout_d;
  end
endmodule

// File: tb/tb_bsh_core.sv
module tb_bsh_core;
  logic        clk;
  logic        rst_n;
  logic [31:0] op;
  logic [2:0]  kind;
  logic [7:0]  amt;
  logic        cin;
  logic [31:0] res;
  logic        cout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bsh_core dut (
    .clk(clk), .rst_n(rst_n), .op(op), .kind(kind),
    .amt(amt), .cin(cin), .res(res), .cout(cout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural model: one bit position per step.
  function automatic logic [32:0] model(logic [31:0] a, int k, int n, logic ci);
    logic [31:0] r = a;
    logic        c = ci;
    case (k)
      0: for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end
      1: for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end
      2: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
      3: if (n != 0) begin
           for (int i = 0; i < n % 32; i++) r = {r[0], r[31:1]};
           c = r[31];
         end
      4: begin c = a[0]; r = {ci, a[31:1]}; end
      default: ;
    endcase
    return {c, r};
  endfunction

  function automatic string tag(int k, int n);
    if (k >= 5) return "R9";
    if (k == 4) return "R8";
    if (n == 0) return "R2";
    if (k == 0) return (n > 32) ? "R4" : "R3";
    if (k == 1) return "R5";
    if (k == 2) return "R6";
    return "R7";
  endfunction

  task automatic apply(logic [31:0] a, int k, int n, logic ci);
    logic [32:0] exp;
    op = a; kind = 3'(k); amt = 8'(n); cin = ci;
    exp = model(a, k, n, ci);
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if ({cout, res} !== exp) begin
      n_fail++;
      $display("FAIL %s kind=%0d amt=%0d op=%h cin=%0b: got res=%h cout=%0b, expected res=%h cout=%0b",
               tag(k, n), k, n, a, ci, res, cout, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    if (!done) $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op = 32'hdead_beef; kind = 3'd3; amt = 8'd5; cin = 1'b1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (res !== 32'h0 || cout !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got res=%h cout=%0b, expected res=0 cout=0", res, cout);
    end
    rst_n = 1'b1;

    // R3: carry taken from op[0] at exactly 32, and from op[32-n] in range
    apply(32'h0000_0001, 0, 32, 1'b0);
    apply(32'h0000_0010, 0, 28, 1'b0);
    // R4: over-width left shift
    apply(32'hffff_ffff, 0, 33, 1'b1);
    // R5: logical right at 32 and above
    apply(32'h8000_0000, 1, 32, 1'b0);
    apply(32'hffff_ffff, 1, 200, 1'b1);
    // R6: negative operand, in range and over width
    apply(32'h8000_0004, 2, 3, 1'b0);
    apply(32'h8000_0000, 2, 40, 1'b0);
    apply(32'h7fff_ffff, 2, 255, 1'b1);
    // R7: rotate by multiples of 32 and by 36
    apply(32'h8000_0001, 3, 32, 1'b0);
    apply(32'h0000_0010, 3, 36, 1'b0);
    // R8: carry enters bit 31, amount ignored
    apply(32'h0000_0003, 4, 77, 1'b1);
    // R9: undefined code keeps operand and carry
    apply(32'h1234_5678, 6, 9, 1'b1);
    // R2: zero amount keeps carry
    apply(32'hcafe_f00d, 0, 0, 1'b1);

    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 256; n++)
        apply($urandom, k, n, 1'($urandom));

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule